// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block produces the address, address-valid window, read strobe and write strobe for one external data memory access, on behalf of an 8051-style core. A 3-bit stretch setting makes every access longer by a chosen number of clocks, so slow memories can be served without a wait-state input. Read accesses and write accesses grow in different ways with the setting. A write keeps one clock of address and data setup before its strobe, and up to two clocks of hold after it.

The core raises a request with direction, address and write data while the block is idle. The block latches the request and the stretch setting, then runs the access. It captures read data on the last clock of the read strobe and raises a one-clock done pulse on the final clock, after which the core may continue. While an access runs, `busy` is high and further requests are ignored.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: The stretch value s equals the binary value of `stretch_sel[2:0]`, from 0 to 7.
- R2: For a read, `addr_valid` is high for exactly s+1 consecutive clocks and `rd_strobe` is high on exactly those same clocks.
- R3: For a write, `addr_valid` is high for exactly s+2 consecutive clocks and `rd_strobe` stays low.
- R4: For a write, `wr_strobe` is high for 1 clock when s is 0 or 1, and for s-1 clocks when s is 2 to 7.
- R5: `wr_strobe` never rises on the first clock of the window; it rises on the second window clock. `mem_addr` and `mem_wdata` stay constant while `addr_valid` is high, and the two strobes are never high together.
- R6: `rdata_out` takes the value of `mem_rdata` present on the last clock of the read strobe and holds it from the following clock.
- R7: `done` is high for exactly one clock, the final clock of the address window, for both reads and writes.
- R8: `stretch_sel` is sampled when a request is accepted; a change during the access does not alter that access.
- R9: A request is accepted on a clock edge where `req_valid` is high and `busy` is low; the window starts on the next clock. `busy` is high on every window clock and low afterwards. A request raised while busy is ignored and does not start an access after the current one ends.
- R10: While `rst_n` is low, `addr_valid`, `rd_strobe`, `wr_strobe`, `done` and `busy` are all low. The reset is applied at once and released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| stretch_sel | input | SEL_W | Stretch setting |
| mem_rdata | input | DATA_W | Read data from the memory |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wdata | output | DATA_W | Write data to the memory |
| addr_valid | output | 1 | Address-valid window |
| rd_strobe | output | 1 | Active-high read strobe |
| wr_strobe | output | 1 | Active-high write strobe |
| rdata_out | output | DATA_W | Captured read data |
| done | output | 1 | One-clock pulse on the last window clock |
| busy | output | 1 | Access in progress |

## Verification
The bench runs every stretch value for both directions, then random accesses. It goes after the stretch 0/1 write strobe, where a design that applies s-1 without a floor would give a zero-width or wrapped strobe. It also checks that read data comes from the last strobe clock, not the first, and that a stretch or request change during an access neither resizes that access nor queues a second one. A reset in the middle of a long write must drop every strobe at once, not after the window ends.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xs_state_t;

endpackage

// File: rtl/xmem_cycle_calc.sv
module xmem_cycle_calc #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [SEL_W-1:0] stretch_sel,
  input  logic             is_write,
  output logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] strb_len
);

  logic [CNT_W-1:0] s_ext;

  always_comb begin
    s_ext = CNT_W'(stretch_sel);
    // R2/R3: window is s+1 clocks for a read, s+2 for a write
    last_idx = is_write ? s_ext + CNT_W'(1) : s_ext;
    // R4: write strobe floors at one clock
    strb_len = (s_ext < CNT_W'(2)) ? CNT_W'(1) : s_ext - CNT_W'(1);
  end

endmodule

// File: rtl/xmem_cycle_fsm.sv
module xmem_cycle_fsm
  import xmem_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic [CNT_W-1:0] last_idx_in,
  input  logic [CNT_W-1:0] strb_len_in,
  output logic             active,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             done,
  output logic             capture
);

  xs_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] slen_q, slen_d;
  logic             at_last;

  assign active  = (state_q != XS_IDLE);
  assign at_last = active && (cnt_q == last_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    slen_d  = slen_q;
    unique case (state_q)
      XS_IDLE: begin
        if (start) begin
          state_d = start_write ? XS_WRITE : XS_READ;
          cnt_d   = '0;
          last_d  = last_idx_in;   // R8: configuration frozen here
          slen_d  = strb_len_in;
        end
      end
      XS_READ, XS_WRITE: begin
        if (at_last) begin
          state_d = XS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      slen_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      slen_q  <= slen_d;
    end
  end

  assign rd_strobe = (state_q == XS_READ);
  // R5: one setup clock before the write strobe
  assign wr_strobe = (state_q == XS_WRITE) && (cnt_q != '0) && (cnt_q <= slen_q);
  assign done      = at_last;
  assign capture   = at_last && (state_q == XS_READ);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= last_q));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  p_strobe_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe || wr_strobe) |-> active);
  p_wr_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !wr_strobe);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!active && !rd_strobe && !wr_strobe && !done);
    end
  end

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEL_W-1:0]  stretch_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              addr_valid,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] rdata_out,
  output logic              done,
  output logic              busy
);

  localparam int MAX_WIN = (1 << SEL_W) + 1;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              accept;
  logic              active;
  logic              capture;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  strb_len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // R10: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign accept = req_valid && !active;   // R9

  xmem_cycle_calc #(.SEL_W(SEL_W), .CNT_W(CNT_W)) calc_i (
    .stretch_sel (stretch_sel),
    .is_write    (req_write),
    .last_idx    (last_idx),
    .strb_len    (strb_len)
  );

  xmem_cycle_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (accept),
    .start_write (req_write),
    .last_idx_in (last_idx),
    .strb_len_in (strb_len),
    .active      (active),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .done        (done),
    .capture     (capture)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // R6: sample on the final read strobe clock
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   rdata_q <= '0;
    else if (capture) rdata_q <= mem_rdata;
  end

  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rdata_out  = rdata_q;
  assign addr_valid = active;
  assign busy       = active;

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (active && $past(active)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    !capture |=> $stable(rdata_out));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (active && !done) |=> active);

endmodule

// File: tb/xmem_stretch_ctrl_tb_top.sv
module xmem_stretch_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [2:0]  stretch_sel;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        addr_valid;
  logic        rd_strobe;
  logic        wr_strobe;
  logic [7:0]  rdata_out;
  logic        done;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  xmem_stretch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stretch_sel(stretch_sel),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .addr_valid(addr_valid), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .rdata_out(rdata_out), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int exp_win(bit wr, int s);
    return wr ? s + 2 : s + 1;            // R2, R3
  endfunction

  function automatic int exp_wstrb(int s);
    return (s < 2) ? 1 : s - 1;           // R4
  endfunction

  function automatic logic [7:0] rd_pat(logic [15:0] a, int k);
    return a[7:0] ^ 8'(k * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [7:0] d, int s, bit disturb);
    int win = 0, rdn = 0, wrn = 0, first_wr = -1, donen = 0, done_k = -1;
    bit addr_bad = 0, busy_bad = 0;
    logic [7:0] exp_rd = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    stretch_sel = 3'(s);
    @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      if (k == 0) begin
        if (disturb) begin
          stretch_sel = ~3'(s); req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        end else begin
          req_valid = 0;
        end
      end
      mem_rdata = rd_pat(a, k);
      if (addr_valid) win++;
      if (rd_strobe) rdn++;
      if (wr_strobe) begin
        wrn++;
        if (first_wr < 0) first_wr = k;
      end
      if (addr_valid && (mem_addr != a || (wr && mem_wdata != d))) addr_bad = 1;
      if (addr_valid && !busy) busy_bad = 1;
      if (done) begin
        donen++;
        done_k = k;
        exp_rd = rd_pat(a, k);
        req_valid = 0;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(win == exp_win(wr, s), wr ? "R3 window" : "R2 window", win, exp_win(wr, s));
    if (wr) begin
      chk(rdn == 0, "R3 no read strobe", rdn, 0);
      chk(wrn == exp_wstrb(s), "R4 write strobe width", wrn, exp_wstrb(s));
      chk(first_wr == 1, "R5 write strobe position", first_wr, 1);
    end else begin
      chk(rdn == exp_win(0, s), "R2 read strobe width", rdn, exp_win(0, s));
      chk(wrn == 0, "R2 no write strobe", wrn, 0);
      chk(rdata_out == exp_rd, "R6 captured data", int'(rdata_out), int'(exp_rd));
    end
    chk(donen == 1 && done_k == exp_win(wr, s) - 1, "R7 done placement",
        done_k, exp_win(wr, s) - 1);
    chk(!addr_bad, "R5 address and data stable", int'(addr_bad), 0);
    chk(!busy_bad, "R9 busy during window", int'(busy_bad), 0);
    if (disturb) begin
      chk(!busy && !addr_valid, "R8 R9 ignored request not started",
          int'(busy), 0);
    end else begin
      chk(!busy && !addr_valid, "R9 idle after done", int'(busy), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    stretch_sel = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !rd_strobe && !wr_strobe && !done && !busy,
        "R10 reset state", int'({addr_valid, rd_strobe, wr_strobe, done, busy}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !busy, "R9 no request stays idle", int'(busy), 0);

    // R1: every stretch code, both directions
    for (int s = 0; s < 8; s++) begin
      access(1'b0, 16'h1200 + 16'(s), 8'h00, s, 1'b0);
      access(1'b1, 16'h3400 + 16'(s), 8'hA0 + 8'(s), s, 1'b0);
    end
    // R8: change mid access, with request held while busy
    access(1'b0, 16'hBEEF, 8'h00, 1, 1'b1);
    access(1'b1, 16'hCAFE, 8'h5A, 6, 1'b1);

    for (int i = 0; i < 60; i++) begin
      access(1'($urandom), 16'($urandom), 8'($urandom), int'($urandom_range(0, 7)),
             1'($urandom));
    end

    // R10: reset in the middle of a long write
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h7777; stretch_sel = 3'd7;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    #1;
    chk(!addr_valid && !rd_strobe && !wr_strobe && !done && !busy,
        "R10 reset mid access", int'({addr_valid, rd_strobe, wr_strobe, done, busy}), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    access(1'b0, 16'h0042, 8'h00, 0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule